// File: doc/BRIEF.md
# Sticky Status and Fault Register Bank

This block keeps the status logic of a programmable instrument. Nine live condition inputs are registered once per clock into a live status image. Three more registers share the same bit layout:

- a sticky (accumulated) register, which remembers any condition that was seen since its last read;
- a host-written mask register;
- a fault register, which captures masked 0-to-1 transitions of the status bits.

A single summary flag shows that some fault bit is pending. An external status-byte builder uses that flag.

A host reaches the bank through a simple strobe port. It selects one of four registers with a 2-bit address and reads the raw word one cycle later. Reads of the sticky and fault registers have side effects:

- Reading the sticky register reloads it with the current conditions, not with zero.
- Reading the fault register clears it, except for edges that arrive in that same cycle.

Text formatting and command parsing are handled elsewhere.

Top module: `psu_status_bank`

## Requirements
- R1: The register word is 9 bits wide, and every register uses the same layout. Bit 0 is constant-voltage mode and bit 1 is constant-current mode. Bit 2 is overrange, bit 3 is overvoltage trip and bit 4 is overtemperature trip. Bit 5 is AC line fault, bit 6 is foldback trip, bit 7 is remote programming error and bit 8 is remote inhibit. The register addresses are: 0 live status, 1 sticky, 2 mask, 3 fault.
- R2: The live status equals the condition inputs sampled at the previous clock edge. It does not latch.
- R3: A sticky bit is 1 if its status bit has been 1 at any clock edge since the last sticky read.
- R4: A sticky read returns the value from before the reload. The register is then reloaded with the conditions sampled at the read edge, so a condition that is true in the read cycle remains set.
- R5: A fault bit is set only when its status bit goes from 0 to 1 while its mask bit is 1. A held level, a falling edge and an unmasked edge set nothing.
- R6: A fault read returns the pre-read value and clears the register. A masked rising edge in the read cycle stays set.
- R7: `fault_any_o` is 1 exactly when some fault bit is 1.
- R8: Only a write to address 2 changes the mask. Writes to the other addresses are ignored.
- R9: Read data and `rvalid_o` appear in the cycle after the read strobe. `rvalid_o` is 0 in every cycle that does not follow a read.
- R10: Synchronous reset has these effects:
  - the mask becomes 0;
  - the fault register becomes 0;
  - the status and sticky registers both load the conditions present at the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 9 | Live condition inputs |
| host_rd_i | input | 1 | Read strobe |
| host_wr_i | input | 1 | Write strobe |
| host_addr_i | input | 2 | Register select |
| host_wdata_i | input | 9 | Write data (mask) |
| host_rdata_o | output | 9 | Registered read data |
| host_rvalid_o | output | 1 | Read data valid |
| fault_any_o | output | 1 | Any fault bit pending |

## Verification
The bench builds the block with the default width of nine conditions. At that width every named condition bit can be driven, so the full layout is exercised: the top weight (remote inhibit), the middle trip bits and the two mode bits. Directed scenarios cover the following:
- rises that the mask passes and rises that it blocks;
- held levels and falling edges;
- one-cycle pulses that only the sticky register can catch;
- same-cycle collisions of a read with a new condition, for both the sticky and the fault register.

// File: rtl/psu_status_pkg.sv
package psu_status_pkg;
  localparam int unsigned NUM_COND = 9;
  localparam int unsigned SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_LIVE   = 2'd0,
    SEL_STICKY = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_FAULT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/psu_status_sampler.sv
module psu_status_sampler #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] status_q;

  always_ff @(posedge clk) begin
    status_q <= cond_i;
  end

  // a rise is judged on the sample that is about to be taken; reset masks it
  assign rise_o   = rst ? '0 : (cond_i & ~status_q);
  assign status_o = status_q;
endmodule

// File: rtl/psu_sticky_reg.sv
module psu_sticky_reg #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] sticky_o
);
  logic [W-1:0] sticky_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || rd_clr_i) begin
        sticky_q[b] <= cond_i[b];
      end else begin
        sticky_q[b] <= sticky_q[b] | cond_i[b];
      end
    end
  end

  assign sticky_o = sticky_q;
endmodule

// File: rtl/psu_fault_reg.sv
module psu_fault_reg #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rise_i,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] fault_o,
  output logic         fault_any_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] fault_q;
  logic [W-1:0] fault_d;
  logic         any_q;

  always_comb begin
    fault_d = (rd_clr_i ? '0 : fault_q) | (rise_i & mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      fault_q <= '0;
      any_q   <= 1'b0;
    end else begin
      if (wr_mask_i) begin
        mask_q <= wdata_i;
      end
      fault_q <= fault_d;
      any_q   <= |fault_d;
    end
  end

  assign mask_o      = mask_q;
  assign fault_o     = fault_q;
  assign fault_any_o = any_q;
endmodule

// File: rtl/psu_read_port.sv
module psu_read_port
  import psu_status_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] sticky_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] fault_i,
  output logic [W-1:0] rdata_o,
  output logic         rvalid_o
);
  logic [W-1:0] pick;
  logic [W-1:0] rdata_q;
  logic         rvalid_q;

  always_comb begin
    unique case (sel_i)
      SEL_LIVE:   pick = status_i;
      SEL_STICKY: pick = sticky_i;
      SEL_MASK:   pick = mask_i;
      default:    pick = fault_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) begin
        rdata_q <= pick;
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/psu_status_bank.sv
module psu_status_bank
  import psu_status_pkg::*;
#(
  parameter int unsigned W = NUM_COND
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     cond_i,
  input  logic             host_rd_i,
  input  logic             host_wr_i,
  input  logic [SEL_W-1:0] host_addr_i,
  input  logic [W-1:0]     host_wdata_i,
  output logic [W-1:0]     host_rdata_o,
  output logic             host_rvalid_o,
  output logic             fault_any_o
);
  reg_sel_e     sel;
  logic [W-1:0] status_q;
  logic [W-1:0] rise;
  logic [W-1:0] acc_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] fault_q;
  logic         rd_sticky;
  logic         rd_fault;
  logic         wr_mask;

  assign sel       = reg_sel_e'(host_addr_i);
  assign rd_sticky = host_rd_i && (sel == SEL_STICKY);
  assign rd_fault  = host_rd_i && (sel == SEL_FAULT);
  assign wr_mask   = host_wr_i && (sel == SEL_MASK);

  psu_status_sampler #(.W(W)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .cond_i   (cond_i),
    .status_o (status_q),
    .rise_o   (rise)
  );

  psu_sticky_reg #(.W(W)) u_sticky (
    .clk      (clk),
    .rst      (rst),
    .cond_i   (cond_i),
    .rd_clr_i (rd_sticky),
    .sticky_o (acc_q)
  );

  psu_fault_reg #(.W(W)) u_fault (
    .clk         (clk),
    .rst         (rst),
    .rise_i      (rise),
    .wr_mask_i   (wr_mask),
    .wdata_i     (host_wdata_i),
    .rd_clr_i    (rd_fault),
    .mask_o      (mask_q),
    .fault_o     (fault_q),
    .fault_any_o (fault_any_o)
  );

  psu_read_port #(.W(W)) u_rport (
    .clk      (clk),
    .rst      (rst),
    .rd_i     (host_rd_i),
    .sel_i    (sel),
    .status_i (status_q),
    .sticky_i (acc_q),
    .mask_i   (mask_q),
    .fault_i  (fault_q),
    .rdata_o  (host_rdata_o),
    .rvalid_o (host_rvalid_o)
  );
endmodule

// File: rtl/psu_status_checker.sv
module psu_status_checker #(
  parameter int unsigned W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] cond_i,
  input logic         host_rd_i,
  input logic         host_wr_i,
  input logic [1:0]   host_addr_i,
  input logic         host_rvalid_o,
  input logic         fault_any_o,
  input logic [W-1:0] status_q,
  input logic [W-1:0] acc_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] fault_q
);
  // R2: live image tracks the previous sample
  a_r2_status_tracks: assert property (@(posedge clk) disable iff (rst)
    status_q == $past(cond_i));

  // R3: sticky always covers the live image
  a_r3_sticky_covers: assert property (@(posedge clk) disable iff (rst)
    (acc_q & status_q) == status_q);

  // R4: after a sticky read the register holds exactly the new status
  a_r4_sticky_reload: assert property (@(posedge clk) disable iff (rst)
    $past(host_rd_i && host_addr_i == 2'd1) |-> acc_q == status_q);

  // R5: new fault bits need a masked rising edge
  a_r5_fault_masked_rise: assert property (@(posedge clk) disable iff (rst)
    (fault_q & ~$past(fault_q) & ~($past(mask_q) & status_q & ~$past(status_q))) == '0);

  // R6: after a fault read only fresh masked edges remain
  a_r6_fault_clear: assert property (@(posedge clk) disable iff (rst)
    $past(host_rd_i && host_addr_i == 2'd3) |->
      fault_q == ($past(mask_q) & status_q & ~$past(status_q)));

  // R7: summary flag matches the fault register
  a_r7_any_flag: assert property (@(posedge clk) disable iff (rst)
    fault_any_o == (|fault_q));

  // R8: mask changes only on a mask write
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(host_wr_i && host_addr_i == 2'd2) |-> $stable(mask_q));

  // R9: valid follows the read strobe by one cycle
  a_r9_rvalid: assert property (@(posedge clk) disable iff (rst)
    host_rvalid_o == $past(host_rd_i));
endmodule

bind psu_status_bank psu_status_checker #(.W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cond_i        (cond_i),
  .host_rd_i     (host_rd_i),
  .host_wr_i     (host_wr_i),
  .host_addr_i   (host_addr_i),
  .host_rvalid_o (host_rvalid_o),
  .fault_any_o   (fault_any_o),
  .status_q      (status_q),
  .acc_q         (acc_q),
  .mask_q        (mask_q),
  .fault_q       (fault_q)
);

// File: tb/psu_status_bank_tb.sv
module psu_status_bank_tb;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] cond_i = '0;
  logic         host_rd_i = 1'b0;
  logic         host_wr_i = 1'b0;
  logic [1:0]   host_addr_i = '0;
  logic [W-1:0] host_wdata_i = '0;
  logic [W-1:0] host_rdata_o;
  logic         host_rvalid_o;
  logic         fault_any_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  psu_status_bank #(.W(W)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .cond_i        (cond_i),
    .host_rd_i     (host_rd_i),
    .host_wr_i     (host_wr_i),
    .host_addr_i   (host_addr_i),
    .host_wdata_i  (host_wdata_i),
    .host_rdata_o  (host_rdata_o),
    .host_rvalid_o (host_rvalid_o),
    .fault_any_o   (fault_any_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [1:0] a, output logic [W-1:0] d);
    host_rd_i   = 1'b1;
    host_addr_i = a;
    tick();
    host_rd_i = 1'b0;
    d = host_rdata_o;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [W-1:0] v);
    host_wr_i    = 1'b1;
    host_addr_i  = a;
    host_wdata_i = v;
    tick();
    host_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    cond_i = 9'h005;
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R9 rvalid idle", {8'd0, host_rvalid_o}, 9'd0);
    chk("R10 fault flag", {8'd0, fault_any_o}, 9'd0);
    do_read(2'd2, d); chk("R10 mask", d, 9'h000);
    do_read(2'd3, d); chk("R10 fault", d, 9'h000);
    do_read(2'd1, d); chk("R10 sticky", d, 9'h005);
  endtask

  task automatic t_status();
    logic [W-1:0] d;
    cond_i = 9'h181;
    tick();
    do_read(2'd0, d); chk("R2 live", d, 9'h181);
    chk("R9 rvalid after read", {8'd0, host_rvalid_o}, 9'd1);
    tick();
    chk("R9 rvalid drops", {8'd0, host_rvalid_o}, 9'd0);
    cond_i = 9'h008;
    tick();
    do_read(2'd0, d); chk("R1 overvoltage weight 8", d, 9'h008);
    cond_i = 9'h000;
    tick();
    do_read(2'd0, d); chk("R2 no latch", d, 9'h000);
  endtask

  task automatic t_sticky();
    logic [W-1:0] d;
    cond_i = '0;
    tick();
    do_read(2'd1, d);
    do_read(2'd1, d); chk("R4 reload to zero", d, 9'h000);
    cond_i = 9'h010; tick(); cond_i = 9'h000; tick(); tick();
    do_read(2'd1, d); chk("R3 pulse caught", d, 9'h010);
    do_read(2'd1, d); chk("R4 reload after read", d, 9'h000);
    cond_i = 9'h002; tick();
    do_read(2'd1, d); chk("R3 held level", d, 9'h002);
    do_read(2'd1, d); chk("R4 reload keeps present", d, 9'h002);
    cond_i = 9'h000; tick();
    do_read(2'd1, d);
    do_read(2'd1, d); chk("R4 cleared", d, 9'h000);
    cond_i = 9'h040;
    do_read(2'd1, d); chk("R4 pre-reload value", d, 9'h000);
    cond_i = 9'h000;
    do_read(2'd1, d); chk("R4 same-cycle condition kept", d, 9'h040);
  endtask

  task automatic t_fault();
    logic [W-1:0] d;
    cond_i = '0;
    do_write(2'd2, 9'h018);
    do_read(2'd2, d); chk("R8 mask written", d, 9'h018);
    do_write(2'd0, 9'h1FF);
    do_write(2'd3, 9'h1FF);
    do_read(2'd2, d); chk("R8 other writes ignored", d, 9'h018);
    do_read(2'd3, d); chk("R8 fault not writable", d, 9'h000);
    cond_i = 9'h008; tick();
    chk("R7 flag set", {8'd0, fault_any_o}, 9'd1);
    do_read(2'd3, d); chk("R5 masked rise", d, 9'h008);
    chk("R7 flag cleared", {8'd0, fault_any_o}, 9'd0);
    cond_i = 9'h009; tick();
    do_read(2'd3, d); chk("R5 unmasked rise and held level", d, 9'h000);
    cond_i = 9'h000; tick();
    do_read(2'd3, d); chk("R5 falling edge", d, 9'h000);
    cond_i = 9'h010;
    do_read(2'd3, d); chk("R6 pre-read value", d, 9'h000);
    chk("R6 flag for same-cycle edge", {8'd0, fault_any_o}, 9'd1);
    do_read(2'd3, d); chk("R6 same-cycle edge kept", d, 9'h010);
    do_read(2'd3, d); chk("R6 cleared by read", d, 9'h000);
    cond_i = 9'h000; tick();
    cond_i = 9'h100; tick();
    do_read(2'd3, d); chk("R5 bit8 masked off", d, 9'h000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_status();
    t_sticky();
    t_fault();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule